// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port and an external asynchronous static RAM of 512K locations by 8 bits. A client presents one read or write at a time with a 19-bit location and, for writes, a byte of data. The sequencer registers the request, then drives the memory's active-low select, write and output-enable lines through fixed phases, each lasting a parameter-set number of clocks. Reads return the sampled byte together with a one-cycle completion pulse, and writes return the same pulse. The data bus appears as three separate signals (outgoing byte, its drive enable, incoming byte). Pad buffers lie outside the block.

The controller is a single state machine with five named states. IDLE holds every strobe high and raises `req_ready`. Acceptance (IDLE to SETUP) loads the location and data registers. SETUP lowers select and, for a write, starts driving data while write enable stays high. It lasts `DATA_SETUP` clocks for a write and one clock for a read. SETUP to STROBE lowers write enable for `WR_STROBE` clocks, or output enable for `RD_WAIT` clocks. The read byte is captured on the edge that leaves STROBE. STROBE to RECOVER raises select and both enables and pulses `rsp_done`. A write then takes RECOVER to IDLE, still driving data in RECOVER for hold time. A read takes RECOVER to TURNAROUND for `TURN_CYC` clocks, which lets the memory's outputs float, and then TURNAROUND to IDLE. With a 5 ns clock the defaults exceed the minimum times of the fastest memory speed grade.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in IDLE. A request held during a busy cycle causes no memory cycle and leaves `mem_addr` unchanged. With `req_valid` held high, the next request is taken `DATA_SETUP+WR_STROBE+2` edges after a write's acceptance, or `RD_WAIT+TURN_CYC+3` edges after a read's.
- R3: A read keeps `mem_we_n` at 1, holds `mem_oe_n` low for exactly `RD_WAIT` cycles, and pulses `rsp_done` on the cycle after edge `RD_WAIT+1` following acceptance. At that point `rsp_rdata` equals the byte the memory presented while `mem_oe_n` was low.
- R4: A write holds `mem_we_n` low for exactly `WR_STROBE` consecutive cycles. During those cycles `mem_cs_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1. The write data is driven for exactly `DATA_SETUP` cycles before `mem_we_n` falls.
- R5: `mem_addr` never changes between two consecutive cycles in which `mem_cs_n` is 0.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. Before `mem_dq_oe` rises, `mem_oe_n` has been 1 for at least `TURN_CYC+1` cycles.
- R7: `rsp_done` lasts one cycle per accepted request. For a write it appears on the cycle after edge `DATA_SETUP+WR_STROBE` following acceptance.
- R8: `rsp_rdata` changes only when a read completes, and holds its value across later writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Memory location |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory location bus |
| mem_dq_out | output | 8 | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
The completion pulse of one access and a pending request from the client can coincide: the client keeps `req_valid` high through RECOVER. The bench provokes this by streaming mixed writes and reads with `req_valid` never dropped, and by holding a write request throughout a busy read. It judges the outcome by the exact edge count between acceptances, by the absence of any extra select or write pulse at the memory pins, and by reading back the location the ignored request named. The same back-to-back read-then-write stream exercises the turnaround against the next write's data drive, and a pin monitor measures the gap.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_TURN
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
    import asram_pkg::*;
#(
    parameter int RD_WAIT    = 2,
    parameter int WR_STROBE  = 2,
    parameter int DATA_SETUP = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_t phase,
    output pins_t  pins,
    output logic   sample,
    output logic   done
);

    localparam int MAX_AB = (RD_WAIT > WR_STROBE) ? RD_WAIT : WR_STROBE;
    localparam int MAX_CD = (DATA_SETUP > TURN_CYC) ? DATA_SETUP : TURN_CYC;
    localparam int MAXV   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAXV + 1);

    localparam logic [CNT_W-1:0] LD_ONE  = '0;
    localparam logic [CNT_W-1:0] LD_DS   = CNT_W'(DATA_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_WS   = CNT_W'(WR_STROBE - 1);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

    phase_t           state_q, state_d;
    logic             wr_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;

    asram_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Next-state and phase-length selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = LD_ONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = start_wr ? LD_DS : LD_ONE;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = wr_q ? LD_WS : LD_RD;
                end
            end
            ST_STROBE: begin
                if (tmr_exp) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (wr_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TURN;
                end
            end
            ST_TURN: begin
                if (tmr_exp) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start && state_q == ST_IDLE) begin
                wr_q <= start_wr;
            end
        end
    end

    // Outputs decoded from registered state
    always_comb begin
        pins   = PINS_QUIET;
        sample = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: pins = PINS_QUIET;
            ST_SETUP: begin
                pins.cs_n  = 1'b0;
                pins.drive = wr_q;
            end
            ST_STROBE: begin
                pins.cs_n  = 1'b0;
                pins.we_n  = ~wr_q;
                pins.oe_n  = wr_q;
                pins.drive = wr_q;
                sample     = ~wr_q & tmr_exp;
            end
            ST_RECOVER: begin
                pins.drive = wr_q;
                done       = 1'b1;
            end
            ST_TURN: pins = PINS_QUIET;
            default: pins = PINS_QUIET;
        endcase
    end

    assign phase = state_q;

    // Checker state: strobe width and bus-release gap
    localparam int GAP_MIN = TURN_CYC + 1;
    localparam int GAP_W   = $clog2(GAP_MIN + 1) + 1;
    localparam int WE_W    = $clog2(WR_STROBE + 1) + 1;

    logic [GAP_W-1:0] gap_q;
    logic [WE_W-1:0]  we_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= GAP_W'(GAP_MIN);
            we_len_q <= '0;
        end else begin
            if (!pins.oe_n) begin
                gap_q <= '0;
            end else if (gap_q < GAP_W'(GAP_MIN)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (!pins.we_n) begin
                we_len_q <= we_len_q + 1'b1;
            end else begin
                we_len_q <= '0;
            end
        end
    end

    p_drive_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pins.drive |-> pins.oe_n);

    p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.drive) |-> (gap_q >= GAP_W'(GAP_MIN)));

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.we_n) |-> (we_len_q == WE_W'(WR_STROBE)));

    p_we_context_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.we_n |-> (!pins.cs_n && pins.oe_n && pins.drive));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int RD_WAIT    = 2,
    parameter int WR_STROBE  = 2,
    parameter int DATA_SETUP = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    phase_t            phase;
    pins_t             pins;
    logic              sample;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    assign req_ready = (phase == ST_IDLE);
    assign accept    = req_valid & req_ready;

    asram_fsm #(
        .RD_WAIT    (RD_WAIT),
        .WR_STROBE  (WR_STROBE),
        .DATA_SETUP (DATA_SETUP),
        .TURN_CYC   (TURN_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_wr (req_write),
        .phase    (phase),
        .pins     (pins),
        .sample   (sample),
        .done     (rsp_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign mem_cs_n   = pins.cs_n;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_dq_oe  = pins.drive;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_take_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mem_addr) |-> $past(req_valid && req_ready));

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample) |-> $stable(rsp_rdata));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

    localparam int RD = 2;
    localparam int WS = 2;
    localparam int DS = 1;
    localparam int TC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #2.5 clk = ~clk;

    asram_ctrl #(
        .RD_WAIT(RD), .WR_STROBE(WS), .DATA_SETUP(DS), .TURN_CYC(TC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] init_val(input logic [18:0] a);
        return a[7:0] ^ {a[18:15], a[11:8]} ^ 8'h5C;
    endfunction

    // Memory model
    logic [7:0] mem_arr [logic [18:0]];
    logic [7:0] shadow [logic [18:0]];

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n) mem_arr[mem_addr] = mem_dq_out;
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : init_val(mem_addr);
        else
            mem_dq_in <= 8'hEE;
    end

    function automatic logic [7:0] expect_rd(input logic [18:0] a);
        return shadow.exists(a) ? shadow[a] : init_val(a);
    endfunction

    always @(posedge clk) cyc++;

    // Transaction bookkeeping
    bit         outstanding = 0;
    int         acc_cyc = 0;
    bit         acc_wr = 0;
    logic [7:0] acc_exp = '0;
    int         prev_acc = 0;
    bit         prev_wr = 0;
    bit         have_prev = 0;
    int         n_acc = 0;
    int         n_wr = 0;

    // Pin monitor
    bit          prev_cs_low = 0;
    logic [18:0] prev_addr = '0;
    bit          prev_we_n = 1;
    bit          prev_drive = 0;
    bit          prev_done = 0;
    int          we_len = 0;
    int          drv_len = 0;
    int          oe_hi_len = 100;
    int          n_we = 0;
    int          n_cs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe) chk(mem_oe_n, "R6 drive while output enabled", {31'b0, mem_oe_n}, 1);
            if (!mem_cs_n && prev_cs_low) chk(mem_addr == prev_addr, "R5 address moved under select", mem_addr, prev_addr);
            if (!mem_cs_n && !prev_cs_low) n_cs++;
            if (!mem_we_n) begin
                we_len++;
                chk(!mem_cs_n && mem_oe_n && mem_dq_oe, "R4 write context",
                    {29'b0, mem_cs_n, mem_oe_n, mem_dq_oe}, 3'b011);
                if (prev_we_n) begin
                    n_we++;
                    chk(drv_len == DS, "R4 data setup cycles", drv_len, DS);
                end
            end else begin
                if (!prev_we_n) chk(we_len == WS, "R4 strobe width", we_len, WS);
                we_len = 0;
            end
            if (mem_dq_oe && !prev_drive) chk(oe_hi_len >= TC + 1, "R6 turnaround gap", oe_hi_len, TC + 1);
            if (rsp_done) begin
                chk(!prev_done, "R7 done longer than one cycle", 1, 0);
                chk(outstanding, "R7 done without request", 0, 1);
                if (acc_wr)
                    chk(cyc - acc_cyc == DS + WS, "R7 write done latency", cyc - acc_cyc, DS + WS);
                else begin
                    chk(cyc - acc_cyc == RD + 1, "R3 read done latency", cyc - acc_cyc, RD + 1);
                    chk(rsp_rdata == acc_exp, "R3 read data", rsp_rdata, acc_exp);
                end
                outstanding = 0;
            end
            drv_len     = mem_dq_oe ? drv_len + 1 : 0;
            oe_hi_len   = mem_oe_n ? oe_hi_len + 1 : 0;
            prev_cs_low = !mem_cs_n;
            prev_addr   = mem_addr;
            prev_we_n   = mem_we_n;
            prev_drive  = mem_dq_oe;
            prev_done   = rsp_done;
        end
    end

    // Called at a negedge; returns at the negedge after the accepting edge
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input bit hold, input bit chk_gap);
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (chk_gap && have_prev)
            chk(cyc - prev_acc == (prev_wr ? DS + WS + 2 : RD + TC + 3), "R2 back-to-back spacing",
                cyc - prev_acc, prev_wr ? DS + WS + 2 : RD + TC + 3);
        acc_cyc = cyc;
        acc_wr  = wr;
        acc_exp = wr ? d : expect_rd(a);
        if (wr) begin
            shadow[a] = d;
            n_wr++;
        end
        n_acc++;
        outstanding = 1;
        prev_acc  = cyc;
        prev_wr   = wr;
        have_prev = 1;
        if (!hold) req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (outstanding || !req_ready) @(negedge clk);
    endtask

    function automatic logic [18:0] sweep_addr(input int i);
        return 19'((i * 37) ^ (i << 13) ^ (i << 17));
    endfunction

    initial begin
        logic [18:0] za;
        logic [7:0]  held;
        repeat (3) @(negedge clk);
        // R1: reset state while held and after release
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done && req_ready,
            "R1 reset outputs", {26'b0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready}, 6'b111001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done && req_ready,
            "R1 after release", {26'b0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done, req_ready}, 6'b111001);

        // Sweep: isolated writes then reads (R3, R4, R7)
        for (int i = 0; i < 40; i++) begin
            issue(1'b1, sweep_addr(i), 8'(i * 29 + 7), 1'b0, 1'b0);
            wait_idle();
        end
        for (int i = 0; i < 48; i++) begin
            issue(1'b0, sweep_addr(i), 8'h00, 1'b0, 1'b0);
            wait_idle();
        end

        // Streams with req_valid held across completions (R2, R6)
        have_prev = 0;
        for (int i = 0; i < 24; i++) begin
            issue((i % 3) != 1, 19'h40000 + 19'(i % 5), 8'(8'hA0 + i), 1'b1, 1'b1);
        end
        req_valid = 1'b0;
        wait_idle();
        have_prev = 0;
        for (int i = 0; i < 12; i++) begin
            issue(i[0], 19'h7FFF0 + 19'(i % 4), 8'(8'h33 ^ i), 1'b1, 1'b1);
        end
        req_valid = 1'b0;
        wait_idle();

        // R2: write request held while a read is busy is ignored
        za = 19'h12345;
        issue(1'b0, 19'h00ABC, 8'h00, 1'b0, 1'b0);
        req_write = 1'b1;
        req_addr  = za;
        req_wdata = 8'hFF;
        req_valid = 1'b1;
        while (!rsp_done) @(negedge clk);
        chk(mem_addr == 19'h00ABC, "R2 address kept while busy", mem_addr, 19'h00ABC);
        req_valid = 1'b0;
        wait_idle();
        issue(1'b0, za, 8'h00, 1'b0, 1'b0);
        wait_idle();
        chk(rsp_rdata == init_val(za), "R2 ignored write left memory", rsp_rdata, init_val(za));

        // R8: read data held across a write
        issue(1'b0, sweep_addr(3), 8'h00, 1'b0, 1'b0);
        wait_idle();
        held = rsp_rdata;
        issue(1'b1, 19'h00777, 8'h5A, 1'b0, 1'b0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(rsp_rdata == held, "R8 read data held", rsp_rdata, held);

        // R2: pin activity matches accepted requests only
        chk(n_we == n_wr, "R2 write pulse count", n_we, n_wr);
        chk(n_cs == n_acc, "R2 select pulse count", n_cs, n_acc);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule